// File: doc/BRIEF.md
# Legacy Low-Memory Window Decoder

This block sits on the address path of a host bridge. For each access below 1 MiB it decides whether main DRAM serves the access, whether DRAM serves it as a read-only shadow, or whether it goes out to the PCI bus. The top 64 KiB BIOS window and the twelve 16 KiB option-ROM segments each carry a 2-bit attribute field, held in seven byte-wide configuration registers. A separate control byte decides whether the 128 KiB system-management RAM window at 0xA0000 maps to DRAM. That window opens when the CPU reports system-management mode and an enable bit is set, or when a force-open bit is set.

Software programs the registers through a byte-wide write port. A write takes effect on the clock edge that captures it. The address decode itself is combinational from the stored bytes, the access address, the read/write flag and the mode input. A change on the mode input therefore changes the decode in the same cycle. The block has no state machine. Its only state is the configuration bytes, which reset to all-PCI shadowing and a closed management window. Writes that hit a read-only segment get their own target code so that the fabric can drop them. Addresses at or above 1 MiB are flagged as out of range.

Top module: `lowmem_attr_decoder`

## Requirements
- R1: After reset, the seven attribute bytes are 0x00 and the management control byte is 0x02. As a result, every access from 0xA0000 to 0xFFFFF goes to PCI (code 2) and `smram_visible` is 0 whatever the mode input is.
- R2: Any access with an address below 0xA0000 gives target code 0 (DRAM), for reads and for writes.
- R3: Any address with a set bit at position 20 or above gives target code 4 (out of range).
- R4: Addresses 0xF0000 to 0xFFFFF take their attribute from bits [5:4] of the byte at offset 0x59.
- R5: Segment s (0 to 11) covers 0xC0000 + s*0x4000 through 0xC3FFF + s*0x4000. It takes its attribute from the byte at offset 0x5A + s/2: bits [1:0] when s is even, bits [5:4] when s is odd.
- R6: Attribute 3 gives code 0 (DRAM). Attribute 1 gives code 1 (DRAM read-only) on a read and code 3 (write dropped) on a write. Attributes 0 and 2 give code 2 (PCI).
- R7: `smram_visible` equals (mode input AND control bit 3) OR control bit 6, where the control byte is at offset 0x72. Accesses in 0xA0000 to 0xBFFFF give code 0 when the window is visible and code 2 when it is not.
- R8: A register write changes the decode only from the cycle after the capturing edge. A write to any offset other than 0x59 to 0x5F or 0x72 changes nothing.
- R9: A change on the mode input changes `smram_visible` and the decode of the management window in the same cycle, with no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_addr | input | 8 | Configuration byte offset |
| cfg_wr_data | input | 8 | Configuration byte value |
| smm_active | input | 1 | CPU system-management-mode indication |
| acc_addr | input | ADDR_W (32) | Physical address of the access |
| acc_is_write | input | 1 | 1 for a write access, 0 for a read |
| tgt_code | output | 3 | 0 DRAM, 1 DRAM read-only, 2 PCI, 3 write dropped, 4 out of range |
| smram_visible | output | 1 | Management RAM window currently maps to DRAM |

## Verification
On every cycle the assertions check the following:
- accesses below 0xA0000 go to DRAM;
- high addresses are flagged out of range;
- a read never yields the write-dropped code;
- the management window routes according to `smram_visible`;
- a write to the control byte opens or closes the window on the next cycle, as its bits and the mode input dictate.

Only the bench's scenarios can show the rest: that each of the twelve segments reads its own nibble of its own byte, that the BIOS window reads the right field, that writes to unrelated offsets leave the decode unchanged, and that a write is not yet visible in its own cycle. The bench compares the design against a behavioural model on every cycle, through directed sweeps and a randomized phase.

// File: rtl/lowmem_pkg.sv
package lowmem_pkg;

    typedef enum logic [2:0] {
        TGT_DRAM    = 3'd0,
        TGT_DRAM_RO = 3'd1,
        TGT_PCI     = 3'd2,
        TGT_WR_DROP = 3'd3,
        TGT_OOR     = 3'd4
    } tgt_e;

    typedef enum logic [2:0] {
        REG_LOW   = 3'd0,
        REG_SMRAM = 3'd1,
        REG_SEG   = 3'd2,
        REG_BIOS  = 3'd3,
        REG_OOR   = 3'd4
    } region_e;

    localparam int          ATTR_BYTES  = 7;
    localparam logic [7:0]  ATTR_BASE   = 8'h59;
    localparam logic [7:0]  SMRAM_OFS   = 8'h72;
    localparam logic [7:0]  SMRAM_RST   = 8'h02;
    localparam int          SMRAM_EN_B  = 3;
    localparam int          SMRAM_OPEN_B = 6;

    localparam logic [19:0] LOW_TOP     = 20'hA0000;
    localparam logic [19:0] SMRAM_TOP   = 20'hC0000;
    localparam logic [19:0] SEG_TOP     = 20'hF0000;

endpackage

// File: rtl/lowmem_cfg_regs.sv
module lowmem_cfg_regs
    import lowmem_pkg::*;
#(
    parameter int         N_ATTR   = ATTR_BYTES,
    parameter logic [7:0] BASE_OFS = ATTR_BASE,
    parameter logic [7:0] CTL_OFS  = SMRAM_OFS,
    parameter logic [7:0] CTL_RST  = SMRAM_RST
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [7:0]                 wr_addr,
    input  logic [7:0]                 wr_data,
    output logic [N_ATTR-1:0][7:0]     attr_bytes,
    output logic [7:0]                 smram_ctl
);

    for (genvar g = 0; g < N_ATTR; g++) begin : g_attr
        localparam logic [7:0] MY_OFS = BASE_OFS + 8'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                attr_bytes[g] <= 8'h00;
            end else if (wr_en && (wr_addr == MY_OFS)) begin
                attr_bytes[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smram_ctl <= CTL_RST;
        end else if (wr_en && (wr_addr == CTL_OFS)) begin
            smram_ctl <= wr_data;
        end
    end

endmodule

// File: rtl/lowmem_addr_region.sv
module lowmem_addr_region
    import lowmem_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int N_ATTR    = ATTR_BYTES,
    parameter int SEG_COUNT = 12,
    parameter int SEG_SHIFT = 14
) (
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [N_ATTR-1:0][7:0] attr_bytes,
    output region_e                region,
    output logic [1:0]             attr_field
);

    localparam int SEG_IDX_W = $clog2(SEG_COUNT);
    localparam int BLK_W     = 20 - SEG_SHIFT;
    localparam logic [BLK_W-1:0] SEG_FIRST_BLK = BLK_W'(SMRAM_TOP >> SEG_SHIFT);

    logic [19:0]                   lo_addr;
    logic                          above_1m;
    logic [BLK_W-1:0]              blk_rel;
    logic [SEG_IDX_W-1:0]          seg_idx;
    logic [SEG_COUNT-1:0][1:0]     seg_field;
    logic [1:0]                    seg_sel;

    assign lo_addr  = acc_addr[19:0];
    assign above_1m = |acc_addr[ADDR_W-1:20];
    assign blk_rel  = lo_addr[19:SEG_SHIFT] - SEG_FIRST_BLK;
    assign seg_idx  = blk_rel[SEG_IDX_W-1:0];

    // two segments share each byte: even index low nibble, odd index high nibble
    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
        assign seg_field[g] = attr_bytes[1 + g / 2][(g % 2) * 4 +: 2];
    end

    always_comb begin
        seg_sel = 2'b00;
        for (int k = 0; k < SEG_COUNT; k++) begin
            if (seg_idx == SEG_IDX_W'(k)) begin
                seg_sel = seg_field[k];
            end
        end
    end

    always_comb begin
        if (above_1m) begin
            region     = REG_OOR;
            attr_field = 2'b00;
        end else if (lo_addr >= SEG_TOP) begin
            region     = REG_BIOS;
            attr_field = attr_bytes[0][5:4];
        end else if (lo_addr >= SMRAM_TOP) begin
            region     = REG_SEG;
            attr_field = seg_sel;
        end else if (lo_addr >= LOW_TOP) begin
            region     = REG_SMRAM;
            attr_field = 2'b00;
        end else begin
            region     = REG_LOW;
            attr_field = 2'b00;
        end
    end

endmodule

// File: rtl/lowmem_target_map.sv
module lowmem_target_map
    import lowmem_pkg::*;
(
    input  region_e     region,
    input  logic [1:0]  attr_field,
    input  logic        is_write,
    input  logic [7:0]  smram_ctl,
    input  logic        smm_active,
    output tgt_e        tgt,
    output logic        smram_open
);

    tgt_e attr_tgt;

    assign smram_open = (smm_active && smram_ctl[SMRAM_EN_B]) || smram_ctl[SMRAM_OPEN_B];

    always_comb begin
        unique case (attr_field)
            2'd3:    attr_tgt = TGT_DRAM;
            2'd1:    attr_tgt = is_write ? TGT_WR_DROP : TGT_DRAM_RO;
            default: attr_tgt = TGT_PCI;
        endcase
    end

    always_comb begin
        unique case (region)
            REG_LOW:   tgt = TGT_DRAM;
            REG_SMRAM: tgt = smram_open ? TGT_DRAM : TGT_PCI;
            REG_SEG:   tgt = attr_tgt;
            REG_BIOS:  tgt = attr_tgt;
            default:   tgt = TGT_OOR;
        endcase
    end

endmodule

// File: rtl/lowmem_attr_decoder.sv
module lowmem_attr_decoder
    import lowmem_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SEG_COUNT = 12,
    parameter int SEG_SHIFT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_wr_addr,
    input  logic [7:0]        cfg_wr_data,
    input  logic              smm_active,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_is_write,
    output logic [2:0]        tgt_code,
    output logic              smram_visible
);

    logic [ATTR_BYTES-1:0][7:0] attr_bytes;
    logic [7:0]                 smram_ctl;
    region_e                    region;
    logic [1:0]                 attr_field;
    tgt_e                       tgt;
    logic                       open_w;

    lowmem_cfg_regs #(
        .N_ATTR   (ATTR_BYTES),
        .BASE_OFS (ATTR_BASE),
        .CTL_OFS  (SMRAM_OFS),
        .CTL_RST  (SMRAM_RST)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_addr    (cfg_wr_addr),
        .wr_data    (cfg_wr_data),
        .attr_bytes (attr_bytes),
        .smram_ctl  (smram_ctl)
    );

    lowmem_addr_region #(
        .ADDR_W    (ADDR_W),
        .N_ATTR    (ATTR_BYTES),
        .SEG_COUNT (SEG_COUNT),
        .SEG_SHIFT (SEG_SHIFT)
    ) region_i (
        .acc_addr   (acc_addr),
        .attr_bytes (attr_bytes),
        .region     (region),
        .attr_field (attr_field)
    );

    lowmem_target_map map_i (
        .region     (region),
        .attr_field (attr_field),
        .is_write   (acc_is_write),
        .smram_ctl  (smram_ctl),
        .smm_active (smm_active),
        .tgt        (tgt),
        .smram_open (open_w)
    );

    assign tgt_code      = tgt;
    assign smram_visible = open_w;

endmodule

// File: rtl/lowmem_attr_decoder_chk.sv
module lowmem_attr_decoder_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [7:0]        cfg_wr_addr,
    input logic [7:0]        cfg_wr_data,
    input logic              smm_active,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_is_write,
    input logic [2:0]        tgt_code,
    input logic              smram_visible
);

    logic in_window;
    logic high_addr;
    assign in_window = (acc_addr >= ADDR_W'(32'hA0000)) && (acc_addr < ADDR_W'(32'hC0000));
    assign high_addr = (acc_addr >> 20) != '0;

    a_r2_low_is_dram: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr < ADDR_W'(32'hA0000)) |-> (tgt_code == 3'd0));

    a_r3_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        high_addr |-> (tgt_code == 3'd4));

    a_r6_read_never_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_is_write |-> (tgt_code != 3'd3));

    a_r7_window_open_dram: assert property (@(posedge clk) disable iff (!rst_n)
        (in_window && smram_visible) |-> (tgt_code == 3'd0));

    a_r7_window_closed_pci: assert property (@(posedge clk) disable iff (!rst_n)
        (in_window && !smram_visible) |-> (tgt_code == 3'd2));

    a_r7_force_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_addr == 8'h72 && cfg_wr_data[6]) |=> smram_visible);

    a_r9_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_addr == 8'h72 && !cfg_wr_data[6] && cfg_wr_data[3])
        |=> (smram_visible == smm_active));

    a_r8_closed_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_addr == 8'h72 && cfg_wr_data[6:3] == 4'b0000) |=> !smram_visible);

endmodule

bind lowmem_attr_decoder lowmem_attr_decoder_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_wr_addr   (cfg_wr_addr),
    .cfg_wr_data   (cfg_wr_data),
    .smm_active    (smm_active),
    .acc_addr      (acc_addr),
    .acc_is_write  (acc_is_write),
    .tgt_code      (tgt_code),
    .smram_visible (smram_visible)
);

// File: tb/lowmem_attr_decoder_tb_top.sv
module lowmem_attr_decoder_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_addr = 8'h00;
    logic [7:0]  cfg_wr_data = 8'h00;
    logic        smm_active = 1'b0;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_is_write = 1'b0;
    logic [2:0]  tgt_code;
    logic        smram_visible;

    int errors = 0;
    int checks = 0;

    bit [7:0] cfgm [0:255];
    bit       pend = 0;
    bit [7:0] pend_a = 0;
    bit [7:0] pend_d = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lowmem_attr_decoder dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr_en     (cfg_wr_en),
        .cfg_wr_addr   (cfg_wr_addr),
        .cfg_wr_data   (cfg_wr_data),
        .smm_active    (smm_active),
        .acc_addr      (acc_addr),
        .acc_is_write  (acc_is_write),
        .tgt_code      (tgt_code),
        .smram_visible (smram_visible)
    );

    function automatic bit model_open(bit smm);
        return (smm && cfgm[8'h72][3]) || cfgm[8'h72][6];
    endfunction

    function automatic int model_tgt(bit [31:0] a, bit w, bit smm);
        int f;
        int s;
        if (a >= 32'h100000) return 4;
        if (a < 32'hA0000) return 0;
        if (a < 32'hC0000) return model_open(smm) ? 0 : 2;
        if (a >= 32'hF0000) begin
            f = (cfgm[8'h59] >> 4) & 3;
        end else begin
            s = int'((a - 32'hC0000) / 32'h4000);
            if (s % 2 == 1) f = (cfgm[8'h5A + s / 2] >> 4) & 3;
            else            f = cfgm[8'h5A + s / 2] & 3;
        end
        if (f == 3) return 0;
        if (f == 1) return w ? 3 : 1;
        return 2;
    endfunction

    task automatic apply(input bit wen, input bit [7:0] wa, input bit [7:0] wd,
                         input bit smm, input bit [31:0] a, input bit w, input string tag);
        int  et;
        bit  eo;
        @(posedge clk);
        if (pend) cfgm[pend_a] = pend_d;
        #1;
        cfg_wr_en    = wen;
        cfg_wr_addr  = wa;
        cfg_wr_data  = wd;
        smm_active   = smm;
        acc_addr     = a;
        acc_is_write = w;
        @(negedge clk);
        et = model_tgt(a, w, smm);
        eo = model_open(smm);
        checks++;
        if (int'(tgt_code) != et || smram_visible != eo) begin
            errors++;
            $display("FAIL %s addr=%h wr=%0d smm=%0d: actual tgt=%0d vis=%0d expected tgt=%0d vis=%0d",
                     tag, a, w, smm, tgt_code, smram_visible, et, eo);
        end
        pend   = wen && (wa inside {[8'h59:8'h5F], 8'h72});
        pend_a = wa;
        pend_d = wd;
    endtask

    task automatic wr(input bit [7:0] wa, input bit [7:0] wd, input string tag);
        apply(1'b1, wa, wd, 1'b0, 32'h0, 1'b0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R8 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) cfgm[i] = 8'h00;
        cfgm[8'h72] = 8'h02;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        apply(0, 0, 0, 0, 32'hA0000, 0, "R1");
        apply(0, 0, 0, 1, 32'hB1234, 1, "R1");
        apply(0, 0, 0, 0, 32'hC4000, 0, "R1");
        apply(0, 0, 0, 1, 32'hFFFFF, 0, "R1");

        // R2 low memory
        apply(0, 0, 0, 0, 32'h00000, 0, "R2");
        apply(0, 0, 0, 1, 32'h9FFFF, 1, "R2");

        // R3 out of range
        apply(0, 0, 0, 0, 32'h100000, 0, "R3");
        apply(0, 0, 0, 0, 32'hFFFFFFFF, 1, "R3");

        // R4 and R8: write not visible in its own cycle
        apply(1, 8'h59, 8'h30, 0, 32'hF0000, 0, "R8");
        apply(0, 0, 0, 0, 32'hF0000, 0, "R4");
        apply(0, 0, 0, 0, 32'hFFFFF, 1, "R4");
        wr(8'h59, 8'h10, "R4");
        apply(0, 0, 0, 0, 32'hF8000, 0, "R6");
        apply(0, 0, 0, 0, 32'hF8000, 1, "R6");
        wr(8'h59, 8'h23, "R4");
        apply(0, 0, 0, 0, 32'hF8000, 0, "R6");
        apply(0, 0, 0, 0, 32'hEFFFF, 0, "R4");

        // R5 segment fields
        wr(8'h5A, 8'h31, "R5");
        wr(8'h5B, 8'h13, "R5");
        wr(8'h5C, 8'h20, "R5");
        wr(8'h5D, 8'h03, "R5");
        wr(8'h5E, 8'h12, "R5");
        wr(8'h5F, 8'h31, "R5");
        for (int s = 0; s < 12; s++) begin
            apply(0, 0, 0, 0, 32'hC0000 + s * 32'h4000, 0, "R5");
            apply(0, 0, 0, 0, 32'hC3FFF + s * 32'h4000, 1, "R5");
        end

        // R7 / R9 management window
        wr(8'h72, 8'h08, "R7");
        apply(0, 0, 0, 0, 32'hA8000, 0, "R9");
        apply(0, 0, 0, 1, 32'hA8000, 0, "R9");
        apply(0, 0, 0, 0, 32'hBFFFF, 1, "R9");
        wr(8'h72, 8'h40, "R7");
        apply(0, 0, 0, 0, 32'hA0000, 1, "R7");
        wr(8'h72, 8'h4A, "R7");
        apply(0, 0, 0, 1, 32'hB0000, 0, "R7");
        wr(8'h72, 8'h00, "R7");
        apply(0, 0, 0, 1, 32'hB0000, 0, "R7");

        // R8 unrelated offsets ignored
        wr(8'h58, 8'hFF, "R8");
        wr(8'h60, 8'hFF, "R8");
        wr(8'h71, 8'hFF, "R8");
        wr(8'h73, 8'hFF, "R8");
        apply(0, 0, 0, 1, 32'hA4000, 0, "R8");
        apply(0, 0, 0, 0, 32'hF0000, 1, "R8");
        apply(0, 0, 0, 0, 32'hEC000, 0, "R8");

        // random phase covering R5, R6, R7, R8, R9
        for (int n = 0; n < 600; n++) begin
            bit [7:0]  wa;
            bit [31:0] a;
            case ($urandom % 4)
                0: wa = 8'h59 + 8'($urandom % 7);
                1: wa = 8'h72;
                default: wa = 8'($urandom);
            endcase
            a = 32'h90000 + ($urandom % 32'h80000);
            apply(($urandom % 3) == 0, wa, 8'($urandom), 1'($urandom),
                  a, 1'($urandom), "R6,R5,R7");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule